// File: doc/BRIEF.md
# Exception Entry and Delay-Slot Tracker

This block holds the exception-entry state of a 64-bit processor whose branches have one delay slot. It follows instruction sequencing through three strobes: an instruction begins (`issue_i`), the executing instruction resolves as a taken branch (`br_taken_i`), or the executing instruction faults (`exc_valid_i`). From these it keeps a branch-pending flag with a captured 64-bit target, and a separate flag that marks the executing instruction as a delay-slot instruction. The pending flag is consumed when the delay-slot instruction begins, so it is already low while the slot executes. The separate flag is the one the exception logic reads.

When an exception is signalled, the block writes the exception PC and the delay-slot bit of the cause register, but only if the exception level bit is clear. It always writes the exception code and sets the exception level bit. It then steers the next fetch address to the vector base plus the sign-extended vector offset, and it cancels any pending branch. All pins are plain control and status signals sampled on the clock. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `exc_entry_top`

## Requirements
- R1: While reset is asserted and after it is released, the registers hold these values: exception level 0, delay bit 0, exception code 0, exception PC 0, branch pending 0, in-delay flag 0, and next PC equal to parameter `RESET_PC` (default 0xFFFFFFFFBFC00000).
- R2: A taken-branch strobe with issue and exception both low sets branch pending and captures the target. Pending stays high through idle cycles until the next issue or exception.
- R3: An issue strobe without an exception copies branch pending into the in-delay flag and clears pending. Next PC becomes the captured target if pending was set; otherwise it becomes the issued PC plus 4.
- R4: An exception with exception level clear and the in-delay flag low loads the exception PC with the current PC and clears the delay bit.
- R5: An exception with exception level clear and the in-delay flag high loads the exception PC with the current PC minus 4 and sets the delay bit.
- R6: An exception with exception level already set leaves the exception PC and the delay bit unchanged.
- R7: Every exception loads the 5-bit exception code from `exc_code_i` and sets the exception level bit to 1.
- R8: On an exception, next PC becomes the vector base plus the 16-bit offset sign-extended to 64 bits, with the sum taken modulo 2^64.
- R9: An exception clears branch pending and the in-delay flag. It overrides an issue or taken-branch strobe in the same cycle, which then has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | An instruction begins executing this cycle |
| pc_i | input | 64 | PC of the instruction issued or executing |
| br_taken_i | input | 1 | The executing instruction is a taken branch |
| br_target_i | input | 64 | Target of that branch |
| exc_valid_i | input | 1 | The executing instruction raises an exception |
| exc_code_i | input | 5 | Code of the raised exception |
| vec_base_i | input | 64 | Exception vector base address |
| vec_offset_i | input | 16 | Signed offset from the vector base |
| epc_o | output | 64 | Exception PC register |
| cause_bd_o | output | 1 | Cause delay-slot bit |
| cause_code_o | output | 5 | Cause exception code |
| status_exl_o | output | 1 | Exception level bit |
| next_pc_o | output | 64 | Next fetch address |
| branch_pending_o | output | 1 | Taken branch awaiting its delay slot |
| in_delay_o | output | 1 | Executing instruction sits in a delay slot |

## Verification
On every cycle, assertions check that a qualifying branch arms the pending flag, that an issue moves pending into the in-delay flag, and that an exception sets the exception level and clears both tracking flags. They also check that the exception PC and delay bit follow the in-delay flag or stay put while the level is set, and that next PC lands on the vector. Only the bench scenarios can show the full sequence: branch, delay-slot issue, fault, then a recorded address of the branch itself. The same holds for the vector sum wrapping below zero, for strobes that collide in one cycle and are dropped, and for reset values compared against fixed constants.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  // Decoded sequencing event, one per cycle. Exception outranks issue,
  // issue outranks a taken-branch report.
  typedef enum logic [1:0] {
    EVT_NONE   = 2'd0,
    EVT_BRANCH = 2'd1,
    EVT_ISSUE  = 2'd2,
    EVT_EXC    = 2'd3
  } seq_evt_e;

  localparam int unsigned INSN_BYTES = 4;

endpackage

// File: rtl/exc_evt_decode.sv
module exc_evt_decode
  import exc_entry_pkg::*;
(
  input  logic     exc_valid,
  input  logic     issue,
  input  logic     br_taken,
  output seq_evt_e evt
);

  always_comb begin
    if (exc_valid)     evt = EVT_EXC;
    else if (issue)    evt = EVT_ISSUE;
    else if (br_taken) evt = EVT_BRANCH;
    else               evt = EVT_NONE;
  end

  always_comb begin
    a_r9_exc_wins: assert (!(exc_valid && evt != EVT_EXC) || $isunknown(exc_valid));
  end

endmodule

// File: rtl/exc_slot_tracker.sv
module exc_slot_tracker
  import exc_entry_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  seq_evt_e        evt,
  input  logic [XLEN-1:0] br_target,
  output logic            pending,
  output logic            in_delay,
  output logic [XLEN-1:0] delayed_pc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending    <= 1'b0;
      in_delay   <= 1'b0;
      delayed_pc <= '0;
    end else begin
      unique case (evt)
        EVT_EXC: begin
          pending  <= 1'b0;
          in_delay <= 1'b0;
        end
        EVT_ISSUE: begin
          in_delay <= pending;
          pending  <= 1'b0;
        end
        EVT_BRANCH: begin
          pending    <= 1'b1;
          delayed_pc <= br_target;
        end
        default: ;
      endcase
    end
  end

  a_r2_branch_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == EVT_BRANCH) |=> (pending && delayed_pc == $past(br_target)));

  a_r2_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == EVT_NONE) |=> $stable(pending));

  a_r3_slot_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == EVT_ISSUE) |=> (!pending && in_delay == $past(pending)));

  a_r9_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == EVT_EXC) |=> (!pending && !in_delay));

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned OFF_W = 16
) (
  input  logic [XLEN-1:0]  base,
  input  logic [OFF_W-1:0] offset,
  output logic [XLEN-1:0]  target
);

  logic [XLEN-1:0] off_ext;

  generate
    if (OFF_W >= XLEN) begin : g_trunc
      assign off_ext = offset[XLEN-1:0];
    end else begin : g_sext
      assign off_ext = {{(XLEN-OFF_W){offset[OFF_W-1]}}, offset};
    end
  endgenerate

  assign target = base + off_ext;

endmodule

// File: rtl/exc_cause_regs.sv
module exc_cause_regs
  import exc_entry_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_evt_e          evt,
  input  logic [XLEN-1:0]   pc,
  input  logic              in_delay,
  input  logic [CODE_W-1:0] exc_code,
  output logic [XLEN-1:0]   epc,
  output logic              bd,
  output logic [CODE_W-1:0] code,
  output logic              exl
);

  localparam logic [XLEN-1:0] SLOT_STEP = XLEN'(INSN_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc  <= '0;
      bd   <= 1'b0;
      code <= '0;
      exl  <= 1'b0;
    end else if (evt == EVT_EXC) begin
      if (!exl) begin
        if (in_delay) begin
          epc <= pc - SLOT_STEP;
          bd  <= 1'b1;
        end else begin
          epc <= pc;
          bd  <= 1'b0;
        end
      end
      code <= exc_code;
      exl  <= 1'b1;
    end
  end

  a_r4_plain_epc: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == EVT_EXC && !exl && !in_delay) |=> (epc == $past(pc) && !bd));

  a_r5_slot_epc: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == EVT_EXC && !exl && in_delay) |=> (epc == $past(pc) - SLOT_STEP && bd));

  a_r6_nested_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == EVT_EXC && exl) |=> ($stable(epc) && $stable(bd)));

  a_r7_level_set: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == EVT_EXC) |=> (exl && code == $past(exc_code)));

endmodule

// File: rtl/exc_entry_top.sv
module exc_entry_top
  import exc_entry_pkg::*;
#(
  parameter int unsigned     XLEN     = 64,
  parameter int unsigned     CODE_W   = 5,
  parameter int unsigned     OFF_W    = 16,
  parameter logic [XLEN-1:0] RESET_PC = 64'hFFFF_FFFF_BFC0_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              br_taken_i,
  input  logic [XLEN-1:0]   br_target_i,
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic [XLEN-1:0]   vec_base_i,
  input  logic [OFF_W-1:0]  vec_offset_i,
  output logic [XLEN-1:0]   epc_o,
  output logic              cause_bd_o,
  output logic [CODE_W-1:0] cause_code_o,
  output logic              status_exl_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              branch_pending_o,
  output logic              in_delay_o
);

  localparam logic [XLEN-1:0] SEQ_STEP = XLEN'(INSN_BYTES);

  seq_evt_e        evt;
  logic [XLEN-1:0] delayed_pc;
  logic [XLEN-1:0] vec_target;
  logic [XLEN-1:0] next_pc_q;

  exc_evt_decode u_decode (
    .exc_valid (exc_valid_i),
    .issue     (issue_i),
    .br_taken  (br_taken_i),
    .evt       (evt)
  );

  exc_slot_tracker #(.XLEN(XLEN)) u_tracker (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (evt),
    .br_target  (br_target_i),
    .pending    (branch_pending_o),
    .in_delay   (in_delay_o),
    .delayed_pc (delayed_pc)
  );

  exc_vector_gen #(.XLEN(XLEN), .OFF_W(OFF_W)) u_vector (
    .base   (vec_base_i),
    .offset (vec_offset_i),
    .target (vec_target)
  );

  exc_cause_regs #(.XLEN(XLEN), .CODE_W(CODE_W)) u_cause (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .pc       (pc_i),
    .in_delay (in_delay_o),
    .exc_code (exc_code_i),
    .epc      (epc_o),
    .bd       (cause_bd_o),
    .code     (cause_code_o),
    .exl      (status_exl_o)
  );

  // Fetch steering: exception vector first, then delayed target, then sequential.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_pc_q <= RESET_PC;
    end else begin
      unique case (evt)
        EVT_EXC:   next_pc_q <= vec_target;
        EVT_ISSUE: next_pc_q <= branch_pending_o ? delayed_pc : pc_i + SEQ_STEP;
        default:   ;
      endcase
    end
  end

  assign next_pc_o = next_pc_q;

  a_r8_vector_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid_i |=> (next_pc_o == $past(vec_target)));

  a_r3_target_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && !exc_valid_i && branch_pending_o) |=> (next_pc_o == $past(delayed_pc)));

  a_r9_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_i && !exc_valid_i) |=> $stable(next_pc_o));

endmodule

// File: tb/test_exc_entry_top.sv
`timescale 1ns/1ps
module test_exc_entry_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        issue_i = 1'b0;
  logic [63:0] pc_i = '0;
  logic        br_taken_i = 1'b0;
  logic [63:0] br_target_i = '0;
  logic        exc_valid_i = 1'b0;
  logic [4:0]  exc_code_i = '0;
  logic [63:0] vec_base_i = '0;
  logic [15:0] vec_offset_i = '0;
  logic [63:0] epc_o, next_pc_o;
  logic        cause_bd_o, status_exl_o, branch_pending_o, in_delay_o;
  logic [4:0]  cause_code_o;

  exc_entry_top i_exc_entry_top (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .pc_i(pc_i),
    .br_taken_i(br_taken_i), .br_target_i(br_target_i),
    .exc_valid_i(exc_valid_i), .exc_code_i(exc_code_i),
    .vec_base_i(vec_base_i), .vec_offset_i(vec_offset_i),
    .epc_o(epc_o), .cause_bd_o(cause_bd_o), .cause_code_o(cause_code_o),
    .status_exl_o(status_exl_o), .next_pc_o(next_pc_o),
    .branch_pending_o(branch_pending_o), .in_delay_o(in_delay_o)
  );

  typedef struct {
    string       tag;
    logic [63:0] epc;
    logic        bd;
    logic [4:0]  code;
    logic        exl;
    logic [63:0] npc;
    logic        pend;
    logic        dly;
  } exp_t;

  exp_t sbq[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Reference model state, from the requirements
  logic [63:0] m_epc, m_npc, m_tgt;
  logic        m_bd, m_exl, m_pend, m_dly;
  logic [4:0]  m_code;

  task automatic push(input string tag);
    exp_t e;
    e.tag = tag; e.epc = m_epc; e.bd = m_bd; e.code = m_code; e.exl = m_exl;
    e.npc = m_npc; e.pend = m_pend; e.dly = m_dly;
    sbq.push_back(e);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    m_epc = '0; m_bd = 1'b0; m_code = '0; m_exl = 1'b0;
    m_npc = 64'hFFFF_FFFF_BFC0_0000; m_pend = 1'b0; m_dly = 1'b0; m_tgt = '0;
    #1 push(tag);
  endtask

  task automatic do_issue(input logic [63:0] pc, input string tag);
    @(negedge clk) issue_i = 1'b1; pc_i = pc;
    @(posedge clk); #1 issue_i = 1'b0;
    m_npc = m_pend ? m_tgt : pc + 64'd4;
    m_dly = m_pend; m_pend = 1'b0;
    push(tag);
  endtask

  task automatic do_branch(input logic [63:0] tgt, input string tag);
    @(negedge clk) br_taken_i = 1'b1; br_target_i = tgt;
    @(posedge clk); #1 br_taken_i = 1'b0;
    m_pend = 1'b1; m_tgt = tgt;
    push(tag);
  endtask

  task automatic do_idle(input string tag);
    @(posedge clk); #1 push(tag);
  endtask

  task automatic do_exc(input logic [63:0] pc, input logic [4:0] code,
                        input logic [63:0] vb, input logic [15:0] off,
                        input bit with_issue, input bit with_br, input string tag);
    @(negedge clk);
    exc_valid_i = 1'b1; pc_i = pc; exc_code_i = code;
    vec_base_i = vb; vec_offset_i = off;
    issue_i = with_issue; br_taken_i = with_br; br_target_i = 64'hDEAD_0000;
    @(posedge clk); #1;
    exc_valid_i = 1'b0; issue_i = 1'b0; br_taken_i = 1'b0;
    if (!m_exl) begin
      if (m_dly) begin m_epc = pc - 64'd4; m_bd = 1'b1; end
      else       begin m_epc = pc;         m_bd = 1'b0; end
    end
    m_code = code; m_exl = 1'b1;
    m_npc = vb + {{48{off[15]}}, off};
    m_pend = 1'b0; m_dly = 1'b0;
    push(tag);
  endtask

  // Monitor: compare one expected item per falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        n_cmp++;
        if (epc_o !== e.epc || cause_bd_o !== e.bd || cause_code_o !== e.code ||
            status_exl_o !== e.exl || next_pc_o !== e.npc ||
            branch_pending_o !== e.pend || in_delay_o !== e.dly) begin
          n_bad++;
          $display("FAIL %s: got epc=%h bd=%b code=%0d exl=%b npc=%h pend=%b dly=%b expected epc=%h bd=%b code=%0d exl=%b npc=%h pend=%b dly=%b",
                   e.tag, epc_o, cause_bd_o, cause_code_o, status_exl_o, next_pc_o,
                   branch_pending_o, in_delay_o, e.epc, e.bd, e.code, e.exl, e.npc,
                   e.pend, e.dly);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset("R1 reset values");
    do_issue(64'h1000, "R3 plain issue");
    do_branch(64'h2000, "R2 branch arms");
    do_idle("R2 pending held");
    do_issue(64'h1004, "R3 delay slot entry");
    do_exc(64'h1004, 5'd4, 64'hFFFF_FFFF_8000_0000, 16'h0180, 1'b0, 1'b0,
           "R5 R7 R8 R9 fault in slot");
    do_issue(64'h3000, "R3 issue under level");
    do_exc(64'h3000, 5'd12, 64'h40, 16'hFF80, 1'b0, 1'b0, "R6 R7 R8 nested wrap");
    do_branch(64'h4000, "R2 branch under level");
    do_issue(64'h3004, "R3 slot under level");
    do_exc(64'h3004, 5'd9, 64'h8000, 16'h0000, 1'b0, 1'b0, "R6 nested slot keeps bd");
    do_reset("R1 reset clears level");
    do_issue(64'h500, "R3 issue after reset");
    do_exc(64'h500, 5'd2, 64'h1_0000_0000, 16'h7FFF, 1'b0, 1'b0, "R4 R7 R8 plain fault");
    do_reset("R1 reset again");
    do_issue(64'h600, "R3 issue");
    do_branch(64'h9000, "R2 branch before fault");
    do_exc(64'h600, 5'd31, 64'h200, 16'h0010, 1'b0, 1'b0, "R9 fault cancels pending");
    do_reset("R1 reset third");
    do_branch(64'h7000, "R2 arm");
    do_exc(64'h700, 5'd1, 64'h300, 16'hFFFF, 1'b1, 1'b1, "R9 collision dropped");
    do_idle("R9 state after collision");
    wait (sbq.size() == 0);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule